// File: doc/BRIEF.md
# Serial-Programmed Wiper and Stored-Code Controller

This block is the digital control core of a 256-position digital potentiometer. A write-only three-wire serial stream (active-low select, serial clock, serial data) carries command frames into it. The block keeps two 8-bit codes. The first is a volatile wiper code, which drives the tap-select output. The second is a stored code, which models a non-volatile cell. That cell has a write strobe and a fixed busy interval after each write. On power-up, the stored code is recalled into the wiper.

All three serial inputs are oversampled in the system clock domain through two-stage synchronizers. Bits are shifted on each detected rising edge of the serial clock while select is low. A frame is acted on only when select returns high. Depending on the command in its two leading bits, the frame can:

- load the wiper,
- load the stored code,
- save the wiper into the stored code, or
- recall the stored code into the wiper.

A standby output indicates that the interface is idle and no internal operation is pending.

Top module: `dpot_ctrl`

## Requirements
- R1: While reset is held and during the recall interval after it, `tap_code` is 0x00, `stored_code` is the midscale value 0x80 and `standby` is low.
- R2: `POR_CYC` cycles after reset release, the stored code is copied into the wiper, so `tap_code` equals `stored_code` (0x80 after reset).
- R3: A frame is shifted MSB first on serial-clock rising edges while `cs_n` is low. It is laid out as command bit C1, command bit C0, six padding bits, then data D7..D0, and it takes effect only when `cs_n` rises. Command 00 with exactly 16 clocks loads D7..D0 into the wiper and leaves the stored code unchanged. Code 0x00 selects the tap nearest the low terminal and 0xFF the tap nearest the high terminal.
- R4: Command 01 with exactly 16 clocks loads D7..D0 into the stored code and leaves the wiper unchanged. Every change of the stored code comes with exactly one `nv_wr_stb` pulse.
- R5: Command 10, with either 8 or 16 clocks, copies the current wiper code into the stored code. With 16 clocks the data byte is ignored.
- R6: Command 11, with either 8 or 16 clocks, copies the stored code into the wiper. With 16 clocks the data byte is ignored.
- R7: The following frames change neither code:
  - a frame whose clock count is neither 8 nor 16;
  - an 8-clock frame carrying command 00 or 01.
- R8: A frame that completes while the power-up recall is running, or during the `NV_BUSY_CYC` cycles after a stored-code write, is discarded.
- R9: `standby` is high exactly when the synchronized `cs_n` is high, no recall is running and no stored-code write is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| cs_n | input | 1 | Active-low serial select |
| sclk | input | 1 | Serial clock, data taken on its rising edge |
| din | input | 1 | Serial data |
| tap_code | output | DW | Wiper code selecting the tap |
| stored_code | output | DW | Current content of the modelled non-volatile register |
| nv_wr_stb | output | 1 | One-cycle pulse when the stored code is written |
| standby | output | 1 | Interface idle and no operation pending |

## Verification
The four commands are sent with several distinct data values, including 0x00, 0xFF and alternating patterns. This shows whether data lands in the right register and whether bits are mis-ordered. Copy commands are sent in both the 8-clock and 16-clock forms, with a junk data byte in the long form. A save that stored the junk byte, or a recall that ignored the stored code, is therefore told apart from a correct copy.

Malformed frames are also sent:
- 0, 8 (write command), 12 and 17 clocks, which separate the length check from plain shifting;
- a frame issued during a stored-code busy interval, which shows whether the busy gate works.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

    typedef enum logic [1:0] {
        CMD_LOAD_WIPER = 2'b00,
        CMD_LOAD_STORE = 2'b01,
        CMD_SAVE       = 2'b10,
        CMD_RECALL     = 2'b11
    } dpot_cmd_e;

endpackage

// File: rtl/dpot_serial_rx.sv
module dpot_serial_rx
    import dpot_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic          din,
    output logic          frm_stb,
    output dpot_cmd_e     frm_cmd,
    output logic [DW-1:0] frm_data,
    output logic          frm_long,
    output logic          frm_short,
    output logic          cs_idle
);

    localparam int FB = 2 * DW;
    localparam int CW = $clog2(FB + 2);
    localparam logic [CW-1:0] CNT_SAT  = CW'(FB + 1);
    localparam logic [CW-1:0] CNT_LONG = CW'(FB);
    localparam logic [CW-1:0] CNT_SHRT = CW'(DW);

    typedef struct packed {
        logic [1:0]    cs_sy;
        logic [1:0]    ck_sy;
        logic [1:0]    dn_sy;
        logic          ck_prev;
        logic          cs_prev;
        logic [FB-1:0] sh;
        logic [CW-1:0] cnt;
        logic          stb;
        dpot_cmd_e     cmd;
        logic [DW-1:0] data;
        logic          lng;
        logic          shrt;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d         = rx_q;
        rx_d.cs_sy   = {rx_q.cs_sy[0], cs_n};
        rx_d.ck_sy   = {rx_q.ck_sy[0], sclk};
        rx_d.dn_sy   = {rx_q.dn_sy[0], din};
        rx_d.ck_prev = rx_q.ck_sy[1];
        rx_d.cs_prev = rx_q.cs_sy[1];
        rx_d.stb     = 1'b0;
        if (!rx_q.cs_sy[1]) begin
            if (rx_q.ck_sy[1] && !rx_q.ck_prev) begin
                rx_d.sh = {rx_q.sh[FB-2:0], rx_q.dn_sy[1]};
                if (rx_q.cnt != CNT_SAT) begin
                    rx_d.cnt = rx_q.cnt + 1'b1;
                end
            end
        end else begin
            rx_d.cnt = '0;
        end
        if (rx_q.cs_sy[1] && !rx_q.cs_prev) begin
            rx_d.stb  = 1'b1;
            rx_d.lng  = (rx_q.cnt == CNT_LONG);
            rx_d.shrt = (rx_q.cnt == CNT_SHRT);
            rx_d.data = rx_q.sh[DW-1:0];
            if (rx_q.cnt == CNT_LONG) begin
                rx_d.cmd = dpot_cmd_e'(rx_q.sh[FB-1:FB-2]);
            end else begin
                rx_d.cmd = dpot_cmd_e'(rx_q.sh[DW-1:DW-2]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q         <= '0;
            rx_q.cs_sy   <= 2'b11;
            rx_q.cs_prev <= 1'b1;
            rx_q.cmd     <= CMD_LOAD_WIPER;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign frm_stb   = rx_q.stb;
    assign frm_cmd   = rx_q.cmd;
    assign frm_data  = rx_q.data;
    assign frm_long  = rx_q.lng;
    assign frm_short = rx_q.shrt;
    assign cs_idle   = rx_q.cs_sy[1];

    // R3: a commit strobe lasts one cycle
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.stb |=> !rx_q.stb);

    // R7: a frame cannot be both lengths
    a_r7_len_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.stb |-> !(rx_q.lng && rx_q.shrt));

endmodule

// File: rtl/dpot_nvstore.sv
module dpot_nvstore #(
    parameter int          DW       = 8,
    parameter int          BUSY_CYC = 200,
    parameter logic [DW-1:0] RST_VAL = 8'h80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_val,
    output logic [DW-1:0] val,
    output logic          busy,
    output logic          wr_stb
);

    localparam int BW = $clog2(BUSY_CYC + 1);
    localparam logic [BW-1:0] BUSY_LOAD = BW'(BUSY_CYC);
    localparam logic [BW-1:0] BUSY_LAST = BW'(1);

    typedef struct packed {
        logic [DW-1:0] val;
        logic [BW-1:0] cnt;
        logic          busy;
        logic          stb;
    } nv_t;

    nv_t nv_d, nv_q;

    always_comb begin
        nv_d     = nv_q;
        nv_d.stb = 1'b0;
        if (nv_q.busy) begin
            if (nv_q.cnt == BUSY_LAST) begin
                nv_d.busy = 1'b0;
                nv_d.cnt  = '0;
            end else begin
                nv_d.cnt = nv_q.cnt - 1'b1;
            end
        end else if (wr_req) begin
            nv_d.val  = wr_val;
            nv_d.stb  = 1'b1;
            nv_d.busy = 1'b1;
            nv_d.cnt  = BUSY_LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nv_q     <= '0;
            nv_q.val <= RST_VAL;
        end else begin
            nv_q <= nv_d;
        end
    end

    assign val    = nv_q.val;
    assign busy   = nv_q.busy;
    assign wr_stb = nv_q.stb;

    // R4: stored value only changes on a write request
    a_r4_store_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(nv_q.val) |-> $past(wr_req));

    // R8: controller never requests while busy
    a_r8_no_request_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !nv_q.busy);

endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
    import dpot_pkg::*;
#(
    parameter int DW          = 8,
    parameter int POR_CYC     = 500,
    parameter int NV_BUSY_CYC = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic          din,
    output logic [DW-1:0] tap_code,
    output logic [DW-1:0] stored_code,
    output logic          nv_wr_stb,
    output logic          standby
);

    localparam int PW = $clog2(POR_CYC + 1);
    localparam logic [PW-1:0] POR_LOAD = PW'(POR_CYC);
    localparam logic [PW-1:0] POR_LAST = PW'(1);
    localparam logic [DW-1:0] MIDSCALE = DW'(1) << (DW - 1);

    typedef struct packed {
        logic [DW-1:0] tap;
        logic [PW-1:0] por_cnt;
        logic          por_act;
    } ct_t;

    ct_t ct_d, ct_q;

    logic          frm_stb, frm_long, frm_short, cs_idle;
    dpot_cmd_e     frm_cmd;
    logic [DW-1:0] frm_data;
    logic          nv_req, nv_busy;
    logic [DW-1:0] nv_wval, nv_val;
    logic          frm_ok;

    dpot_serial_rx #(.DW(DW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .din       (din),
        .frm_stb   (frm_stb),
        .frm_cmd   (frm_cmd),
        .frm_data  (frm_data),
        .frm_long  (frm_long),
        .frm_short (frm_short),
        .cs_idle   (cs_idle)
    );

    dpot_nvstore #(.DW(DW), .BUSY_CYC(NV_BUSY_CYC), .RST_VAL(MIDSCALE)) u_nv (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_req (nv_req),
        .wr_val (nv_wval),
        .val    (nv_val),
        .busy   (nv_busy),
        .wr_stb (nv_wr_stb)
    );

    always_comb begin
        ct_d    = ct_q;
        nv_req  = 1'b0;
        nv_wval = frm_data;
        frm_ok  = frm_stb && !ct_q.por_act && !nv_busy &&
                  (frm_long || (frm_short && frm_cmd[1]));
        if (ct_q.por_act) begin
            if (ct_q.por_cnt == POR_LAST) begin
                ct_d.por_act = 1'b0;
                ct_d.por_cnt = '0;
                ct_d.tap     = nv_val;
            end else begin
                ct_d.por_cnt = ct_q.por_cnt - 1'b1;
            end
        end else if (frm_ok) begin
            unique case (frm_cmd)
                CMD_LOAD_WIPER: ct_d.tap = frm_data;
                CMD_LOAD_STORE: nv_req   = 1'b1;
                CMD_SAVE: begin
                    nv_req  = 1'b1;
                    nv_wval = ct_q.tap;
                end
                CMD_RECALL:     ct_d.tap = nv_val;
                default:        ct_d.tap = ct_q.tap;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q.tap     <= '0;
            ct_q.por_cnt <= POR_LOAD;
            ct_q.por_act <= 1'b1;
        end else begin
            ct_q <= ct_d;
        end
    end

    assign tap_code    = ct_q.tap;
    assign stored_code = nv_val;
    assign standby     = cs_idle && !ct_q.por_act && !nv_busy;

    // R2: wiper equals stored code when recall completes
    a_r2_recall_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ct_q.por_act) |-> (tap_code == stored_code));

    // R1: wiper holds during the recall interval
    a_r1_hold_during_recall: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_q.por_act && $past(ct_q.por_act)) |-> $stable(ct_q.tap));

    // R3: wiper moves only after a frame commit or recall end
    a_r3_tap_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ct_q.tap) |-> ($past(frm_stb) || $fell(ct_q.por_act)));

    // R9: no standby in the cycle a store write begins
    a_r9_standby_vs_write: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wr_stb |-> !standby);

endmodule

// File: tb/sim_dpot_ctrl.sv
module sim_dpot_ctrl;

    localparam int DW    = 8;
    localparam int POR   = 500;
    localparam int BUSY  = 200;
    localparam int HALF  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic din = 1'b0;
    logic [DW-1:0] tap_code, stored_code;
    logic nv_wr_stb, standby;

    int checks = 0;
    int errors = 0;
    int stb_seen = 0;
    bit done = 1'b0;

    typedef struct {
        logic [DW-1:0] tap;
        logic [DW-1:0] nv;
        string         req;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    dpot_ctrl #(.DW(DW), .POR_CYC(POR), .NV_BUSY_CYC(BUSY)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .din         (din),
        .tap_code    (tap_code),
        .stored_code (stored_code),
        .nv_wr_stb   (nv_wr_stb),
        .standby     (standby)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && nv_wr_stb) stb_seen++;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk({e.req, " tap"}, int'(tap_code), int'(e.tap));
            chk({e.req, " stored"}, int'(stored_code), int'(e.nv));
        end
    end

    task automatic send(input logic [1:0] cmd, input logic [7:0] data, input int n);
        logic [15:0] w;
        w = {cmd, 6'b000000, data};
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            din = (i < 16) ? w[15-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic expect_state(input logic [7:0] t, input logic [7:0] v, input string req);
        exp_t e;
        e.tap = t;
        e.nv  = v;
        e.req = req;
        sb_q.push_back(e);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_busy();
        repeat (BUSY + 10) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset values
        chk("R1 tap in reset", int'(tap_code), 'h00);
        chk("R1 stored in reset", int'(stored_code), 'h80);
        chk("R1 standby in reset", int'(standby), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R1 tap during recall", int'(tap_code), 'h00);
        chk("R8 standby during recall", int'(standby), 0);
        // R8: frame during recall discarded
        send(2'b00, 8'h42, 16);
        repeat (POR) @(negedge clk);
        // R2: recall of midscale
        expect_state(8'h80, 8'h80, "R2");
        chk("R9 standby idle", int'(standby), 1);

        // R3: wiper loads, including both ends
        send(2'b00, 8'h5A, 16);
        expect_state(8'h5A, 8'h80, "R3 5A");
        send(2'b00, 8'hFF, 16);
        expect_state(8'hFF, 8'h80, "R3 FF");
        send(2'b00, 8'h00, 16);
        expect_state(8'h00, 8'h80, "R3 00");

        // R4: store load, wiper unchanged, busy hides standby
        send(2'b01, 8'h3C, 16);
        expect_state(8'h00, 8'h3C, "R4");
        chk("R9 standby while busy", int'(standby), 0);
        chk("R4 one strobe", stb_seen, 1);
        wait_busy();
        chk("R9 standby after busy", int'(standby), 1);

        // R6: short recall
        send(2'b11, 8'h00, 8);
        expect_state(8'h3C, 8'h3C, "R6 short");

        // R5: long save ignores junk data
        send(2'b00, 8'hA5, 16);
        send(2'b10, 8'h11, 16);
        expect_state(8'hA5, 8'hA5, "R5 long");
        wait_busy();

        // R6: long recall ignores junk data
        send(2'b00, 8'h07, 16);
        send(2'b11, 8'hEE, 16);
        expect_state(8'hA5, 8'hA5, "R6 long");

        // R5: short save
        send(2'b00, 8'h66, 16);
        send(2'b10, 8'h00, 8);
        expect_state(8'h66, 8'h66, "R5 short");
        wait_busy();
        chk("R4 strobe count", stb_seen, 3);

        // R7: malformed frames
        send(2'b00, 8'h12, 8);
        expect_state(8'h66, 8'h66, "R7 short write");
        send(2'b01, 8'h12, 8);
        expect_state(8'h66, 8'h66, "R7 short store");
        send(2'b00, 8'h12, 12);
        expect_state(8'h66, 8'h66, "R7 12 clocks");
        send(2'b00, 8'h12, 17);
        expect_state(8'h66, 8'h66, "R7 17 clocks");
        send(2'b00, 8'h12, 0);
        expect_state(8'h66, 8'h66, "R7 0 clocks");
        chk("R7 no strobe", stb_seen, 3);

        // R8: frame during store busy discarded
        send(2'b01, 8'h21, 16);
        send(2'b00, 8'h99, 16);
        expect_state(8'h66, 8'h21, "R8 busy");
        wait_busy();
        send(2'b00, 8'h99, 16);
        expect_state(8'h99, 8'h21, "R8 after busy");

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule